// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order integer pipeline and picks, for each of the two ALU operands, where the value should come from. The choices are the value read from the register file, the result waiting in the EX/MEM pipeline register, or the result waiting in the MEM/WB pipeline register. The pipeline's operand multiplexers use the two 2-bit selects it produces.

The decision uses three things: the two source register numbers of the instruction now in ID/EX, the destination register numbers of the two older instructions, and whether each older instruction writes a register. The logic is purely combinational and holds no state. If both older instructions target the same source register, the younger one, in EX/MEM, takes precedence. Register zero is hard-wired and is never a bypass source.

Top module: `fwd_select`

## Requirements
- R1: Each select uses 2'b00 for the register file value, 2'b10 for the EX/MEM result and 2'b01 for the MEM/WB result. The value 2'b11 never appears.
- R2: The first-operand select is 2'b10 when the EX/MEM stage writes a register, its destination is nonzero and its destination equals the first source.
- R3: The second-operand select is 2'b10 under the same EX/MEM conditions, compared against the second source.
- R4: An operand select is 2'b01 when the MEM/WB stage writes a register, its destination is nonzero and equals that operand's source, and the EX/MEM condition for that operand does not hold.
- R5: When both EX/MEM and MEM/WB qualify for the same operand, the select is 2'b10.
- R6: A destination of register 0 never causes a bypass from either stage, even when the source is also register 0 and the write enable is high.
- R7: A stage whose write enable is low never causes a bypass, whatever its destination is. With no qualifying stage the select is 2'b00.
- R8: The two operands are decided independently. Both may bypass in the same evaluation, from the same stage or from different stages, and equal source numbers always give equal selects.
- R9: The selects depend only on the present inputs. They settle within the same clock cycle in which the inputs change, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_src_a | input | RW (5) | First source register number held in ID/EX |
| id_src_b | input | RW (5) | Second source register number held in ID/EX |
| exm_dst | input | RW (5) | Destination register number held in EX/MEM |
| exm_wen | input | 1 | EX/MEM instruction writes a register |
| mwb_dst | input | RW (5) | Destination register number held in MEM/WB |
| mwb_wen | input | 1 | MEM/WB instruction writes a register |
| sel_a | output | 2 | Source select for the first ALU operand |
| sel_b | output | 2 | Source select for the second ALU operand |

## Verification
Both selects are due in the same cycle in which the pipeline contents present to the block. No result is due a cycle later.

The bench models a three-deep instruction pipeline and advances it on the falling clock edge. It compares both selects at the following rising edge, half a period after the inputs settle, against a behavioural model of the priority rules.

The sequences cover:
- back-to-back writes to one register,
- dependencies two instructions apart,
- writes to register 0,
- non-writing instructions whose destination field matches a source,
- a long pseudo-random stream.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  input  logic [RW-1:0] exm_dst,
  input  logic          exm_wen,
  input  logic [RW-1:0] mwb_dst,
  input  logic          mwb_wen,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b
);
  localparam int NOPS = 2;
  localparam logic [RW-1:0] REG_ZERO = '0;

  logic [RW-1:0] src [NOPS];
  logic [1:0]    sel [NOPS];
  logic          ex_live, wb_live;

  assign src[0]  = id_src_a;
  assign src[1]  = id_src_b;
  assign ex_live = exm_wen && (exm_dst != REG_ZERO);
  assign wb_live = mwb_wen && (mwb_dst != REG_ZERO);

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic hit_ex, hit_wb;
    assign hit_ex = ex_live && (exm_dst == src[g]);
    assign hit_wb = wb_live && (mwb_dst == src[g]) && !hit_ex;
    assign sel[g] = {hit_ex, hit_wb};

    always_comb begin
      if (!$isunknown({src[g], exm_dst, exm_wen, mwb_dst, mwb_wen})) begin
        assert_enc_R1: assert (sel[g] != 2'b11) else $error("R1 select 11");
        assert_zero_dst_R6: assert (!(sel[g] == 2'b10 && exm_dst == REG_ZERO) &&
                                    !(sel[g] == 2'b01 && mwb_dst == REG_ZERO))
          else $error("R6 bypass from register zero");
        assert_wen_low_R7: assert (!(sel[g] == 2'b10 && !exm_wen) &&
                                   !(sel[g] == 2'b01 && !mwb_wen))
          else $error("R7 bypass from non-writing stage");
        assert_newest_R5: assert (!(sel[g] == 2'b01 && exm_wen && exm_dst == src[g] &&
                                    exm_dst != REG_ZERO))
          else $error("R5 older result chosen over newer");
      end
    end
  end

  assign sel_a = sel[0];
  assign sel_b = sel[1];

  always_comb begin
    if (!$isunknown({id_src_a, id_src_b, exm_dst, exm_wen, mwb_dst, mwb_wen})) begin
      assert_same_src_R8: assert (id_src_a != id_src_b || sel_a == sel_b)
        else $error("R8 equal sources, unequal selects");
    end
  end
endmodule

// File: tb/test_fwd_select.sv
module test_fwd_select;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] id_src_a, id_src_b, exm_dst, mwb_dst;
  logic       exm_wen, mwb_wen;
  logic [1:0] sel_a, sel_b;

  // instruction in ID/EX (its own dst/wen travel with it)
  logic [4:0] id_dst;
  logic       id_wen;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  fwd_select #(.RW(5)) i_fwd_select (
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .exm_dst(exm_dst), .exm_wen(exm_wen),
    .mwb_dst(mwb_dst), .mwb_wen(mwb_wen),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  function automatic logic [1:0] model(input int src);
    bit ex_ok, wb_ok;
    ex_ok = exm_wen && int'(exm_dst) != 0 && int'(exm_dst) == src;
    wb_ok = mwb_wen && int'(mwb_dst) != 0 && int'(mwb_dst) == src;
    if (ex_ok) return 2'b10;
    if (wb_ok) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag(input int src, input logic [1:0] exp_v, input bit second);
    bit wb_ok;
    wb_ok = mwb_wen && int'(mwb_dst) != 0 && int'(mwb_dst) == src;
    if (exp_v == 2'b10 && wb_ok) return "R5";
    if (exp_v == 2'b10) return second ? "R3" : "R2";
    if (exp_v == 2'b01) return "R4";
    if ((exm_wen && int'(exm_dst) == src) || (mwb_wen && int'(mwb_dst) == src)) return "R6";
    if (int'(exm_dst) == src || int'(mwb_dst) == src) return "R7";
    return "R1";
  endfunction

  task automatic check_one(input logic [1:0] act, input int src, input bit second);
    logic [1:0] e;
    e = model(src);
    tests++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s (R9) op%0d src=%0d act=%b exp=%b", tag(src, e, second),
               second ? 2 : 1, src, act, e);
    end
  endtask

  task automatic check_both();
    @(posedge clk);
    check_one(sel_a, int'(id_src_a), 1'b0);
    check_one(sel_b, int'(id_src_b), 1'b1);
    if (model(int'(id_src_a)) != 2'b00 && model(int'(id_src_b)) != 2'b00) begin
      tests++; // R8: both operands bypass together
      if (sel_a === 2'b00 || sel_b === 2'b00) begin
        fails++;
        $display("FAIL R8 dual bypass act=%b/%b exp=%b/%b", sel_a, sel_b,
                 model(int'(id_src_a)), model(int'(id_src_b)));
      end
    end
  endtask

  // shift pipeline on falling edge and issue a new instruction into ID/EX
  task automatic issue(input bit wen, input int dst, input int s1, input int s2);
    @(negedge clk);
    mwb_dst = exm_dst; mwb_wen = exm_wen;
    exm_dst = id_dst;  exm_wen = id_wen;
    id_dst = 5'(dst); id_wen = wen;
    id_src_a = 5'(s1); id_src_b = 5'(s2);
    check_both();
  endtask

  initial begin
    id_src_a = '0; id_src_b = '0; exm_dst = '0; mwb_dst = '0;
    exm_wen = 1'b0; mwb_wen = 1'b0; id_dst = '0; id_wen = 1'b0;
    // idle pipeline: R1 register file selects
    check_both();
    // back-to-back accumulation into r1: R2, R4, R5
    issue(1, 1, 1, 2);
    issue(1, 1, 1, 3);
    issue(1, 1, 1, 4);
    issue(1, 1, 1, 5);
    // second operand dependencies: R3
    issue(1, 7, 8, 9);
    issue(1, 6, 10, 7);
    issue(1, 11, 12, 7);
    // both operands on same producer and on different producers: R8
    issue(1, 13, 1, 1);
    issue(1, 14, 13, 13);
    issue(1, 15, 14, 13);
    // writes to register 0: R6
    issue(1, 0, 0, 0);
    issue(1, 0, 0, 0);
    issue(0, 0, 0, 0);
    // non-writing instructions with matching destination: R7
    issue(0, 20, 1, 2);
    issue(0, 21, 20, 21);
    issue(0, 3, 20, 21);
    issue(1, 22, 3, 3);
    // pseudo-random stream over a small register window
    for (int i = 0; i < 3000; i++)
      issue(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
            int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule